// File: doc/BRIEF.md
# Virtual Address Segment Checker

This block sorts each virtual address issued by a processor core according to the privilege mode held in the core's status bits. On every request it decodes the operating mode from the two-bit privilege field and the two exception-level flags. It then decides whether the address space in use is the narrow (32-bit) or the wide (64-bit) one. In User mode it also tests the address against the single legal user segment for that width.

The result is registered and appears on the cycle after the request strobe. It carries five things:
- the decoded mode;
- the width flag;
- a segment-hit flag;
- an address-error flag;
- a one-hot choice between the ordinary and the extended TLB-miss vector.

For Supervisor and Kernel modes only the mode and width are reported. A reserved privilege code is flagged on its own output. The TLB lookup and exception sequencing that consume these outputs sit outside the block.

Top module: `vaddr_seg_check`

## Requirements
- R1: Mode code `mode_o` is 2'b00 (Kernel) whenever `exl_i` or `erl_i` is 1, whatever `ksu_i` holds. Otherwise it follows `ksu_i`: 2'b10 is User, 2'b01 is Supervisor, 2'b00 is Kernel and 2'b11 is reserved.
- R2: `wide_o` equals `ux_i` in User mode and `sx_i` in Supervisor mode. It is 0 in Kernel and reserved modes.
- R3: In User mode with `ux_i`=0, an address with bit 31 equal to 0 is legal. The result has `hit_o`=1 and `miss_norm_o`=1.
- R4: In User mode with `ux_i`=0, an address with bit 31 equal to 1 sets `addr_err_o`. Bits 63..32 play no part in this test.
- R5: In User mode with `ux_i`=1, an address below 2^40 (bits 63..40 all 0) is legal. The result has `hit_o`=1 and `miss_ext_o`=1.
- R6: In User mode with `ux_i`=1, any 1 in bits 63..40 sets `addr_err_o`.
- R7: In Kernel, Supervisor and reserved modes, `hit_o`, `addr_err_o`, `miss_norm_o` and `miss_ext_o` are all 0.
- R8: `bad_mode_o` is 1 exactly when the mode code is 2'b11 (reserved) for a request.
- R9: Every output updates on the clock edge that samples `req_i`=1. After an edge that samples `req_i`=0, every output is 0.
- R10: A synchronous active-high `rst_i` drives every output to 0 on the next edge, whatever the inputs.
- R11: When `addr_err_o` is 1, `hit_o`, `miss_norm_o` and `miss_ext_o` are 0. At most one of the two miss-vector outputs is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe |
| va_i | input | 64 | Virtual address |
| ksu_i | input | 2 | Privilege field |
| exl_i | input | 1 | Exception-level flag |
| erl_i | input | 1 | Error-level flag |
| ux_i | input | 1 | User wide-space select |
| sx_i | input | 1 | Supervisor wide-space select |
| mode_o | output | 2 | Decoded mode code |
| wide_o | output | 1 | 64-bit address space in use |
| hit_o | output | 1 | Address lies in the legal user segment |
| addr_err_o | output | 1 | User address error |
| miss_norm_o | output | 1 | Ordinary TLB-miss vector applies |
| miss_ext_o | output | 1 | Extended TLB-miss vector applies |
| bad_mode_o | output | 1 | Reserved privilege code seen |

## Verification
Every combination of the six status bits is crossed with a walking-one address over all 64 bits and a set of edge addresses: zero, 0x7FFF_FFFF, 0x8000_0000, 2^40-1, 2^40, a sign-extended negative and all ones.

The walking one tells bit 31 apart from its neighbours for the narrow test. It tells bit 40 apart from bit 39 for the wide test. It also shows that the upper word is ignored in the narrow space.

The status sweep separates the dominance of the exception flags from the privilege field, and keeps the reserved code apart from the other modes. Idle cycles with junk addresses and a reset asserted during a live request cover the zero-output cases.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    typedef enum logic [1:0] {
        MD_KERN = 2'b00,
        MD_SUPV = 2'b01,
        MD_USER = 2'b10,
        MD_RSVD = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  wide;
        logic  hit;
        logic  err;
        logic  vec_norm;
        logic  vec_ext;
        logic  bad_mode;
    } result_t;

endpackage

// File: rtl/vseg_mode_dec.sv
module vseg_mode_dec
    import vseg_pkg::*;
(
    input  logic [1:0] ksu_i,
    input  logic       exl_i,
    input  logic       erl_i,
    input  logic       ux_i,
    input  logic       sx_i,
    output mode_e      mode_o,
    output logic       wide_o,
    output logic       bad_o
);

    always_comb begin
        mode_o = MD_KERN;
        wide_o = 1'b0;
        bad_o  = 1'b0;
        if (!(exl_i || erl_i)) begin
            unique case (ksu_i)
                2'b10: begin
                    mode_o = MD_USER;
                    wide_o = ux_i;
                end
                2'b01: begin
                    mode_o = MD_SUPV;
                    wide_o = sx_i;
                end
                2'b11: begin
                    mode_o = MD_RSVD;
                    bad_o  = 1'b1;
                end
                default: mode_o = MD_KERN;
            endcase
        end
    end

    always_comb begin
        assert (!bad_o || mode_o == MD_RSVD); // R8
    end

endmodule

// File: rtl/vseg_user_chk.sv
module vseg_user_chk #(
    parameter int VA_W       = 64,
    parameter int NARROW_BIT = 31,
    parameter int WIDE_LSB   = 40
) (
    input  logic [VA_W-1:0] va_i,
    input  logic            wide_i,
    output logic            legal_o
);

    localparam int TOP_W = VA_W - WIDE_LSB;

    logic narrow_ok;
    logic wide_ok;

    // The narrow test reads one bit; the wide test reads the top field.
    assign narrow_ok = ~va_i[NARROW_BIT];

    generate
        if (TOP_W > 0) begin : g_top
            assign wide_ok = (va_i[VA_W-1:WIDE_LSB] == '0);
        end else begin : g_notop
            assign wide_ok = 1'b1;
        end
    endgenerate

    // Bits that neither test reads are gathered here on purpose.
    logic unused_mid;
    assign unused_mid = ^{va_i[WIDE_LSB-1:NARROW_BIT+1], va_i[NARROW_BIT-1:0]};

    assign legal_o = wide_i ? wide_ok : narrow_ok;

endmodule

// File: rtl/vaddr_seg_check.sv
module vaddr_seg_check
    import vseg_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int NARROW_BIT = 31,
    parameter int WIDE_LSB   = 40
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            req_i,
    input  logic [VA_W-1:0] va_i,
    input  logic [1:0]      ksu_i,
    input  logic            exl_i,
    input  logic            erl_i,
    input  logic            ux_i,
    input  logic            sx_i,
    output logic [1:0]      mode_o,
    output logic            wide_o,
    output logic            hit_o,
    output logic            addr_err_o,
    output logic            miss_norm_o,
    output logic            miss_ext_o,
    output logic            bad_mode_o
);

    mode_e   dec_mode;
    logic    dec_wide;
    logic    dec_bad;
    logic    seg_legal;
    result_t res_d;
    result_t res_q;

    vseg_mode_dec u_dec (
        .ksu_i (ksu_i),
        .exl_i (exl_i),
        .erl_i (erl_i),
        .ux_i  (ux_i),
        .sx_i  (sx_i),
        .mode_o(dec_mode),
        .wide_o(dec_wide),
        .bad_o (dec_bad)
    );

    vseg_user_chk #(
        .VA_W      (VA_W),
        .NARROW_BIT(NARROW_BIT),
        .WIDE_LSB  (WIDE_LSB)
    ) u_chk (
        .va_i   (va_i),
        .wide_i (dec_wide),
        .legal_o(seg_legal)
    );

    always_comb begin
        res_d = '0;
        if (req_i) begin
            res_d.mode     = dec_mode;
            res_d.wide     = dec_wide;
            res_d.bad_mode = dec_bad;
            if (dec_mode == MD_USER) begin
                res_d.err      = ~seg_legal;
                res_d.hit      = seg_legal;
                res_d.vec_norm = seg_legal & ~dec_wide;
                res_d.vec_ext  = seg_legal & dec_wide;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) res_q <= '0;
        else       res_q <= res_d;
    end

    assign mode_o      = res_q.mode;
    assign wide_o      = res_q.wide;
    assign hit_o       = res_q.hit;
    assign addr_err_o  = res_q.err;
    assign miss_norm_o = res_q.vec_norm;
    assign miss_ext_o  = res_q.vec_ext;
    assign bad_mode_o  = res_q.bad_mode;

    AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        addr_err_o |-> !(hit_o || miss_norm_o || miss_ext_o)); // R11
    AST_VEC_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({miss_norm_o, miss_ext_o})); // R11
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> {mode_o, wide_o, hit_o, addr_err_o, miss_norm_o, miss_ext_o, bad_mode_o} == '0); // R9
    AST_KERN_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && (exl_i || erl_i)) |=> (mode_o == 2'b00 && !addr_err_o && !hit_o)); // R1
    AST_NARROW_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !exl_i && !erl_i && ksu_i == 2'b10 && !ux_i && va_i[NARROW_BIT]) |=> addr_err_o); // R4
    AST_WIDE_HIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !exl_i && !erl_i && ksu_i == 2'b10 && ux_i && va_i[VA_W-1:WIDE_LSB] == '0)
        |=> (hit_o && miss_ext_o)); // R5
    AST_RSVD_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        bad_mode_o |-> (mode_o == 2'b11 && !hit_o && !addr_err_o)); // R8
    AST_HIT_HAS_VEC: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |-> (miss_norm_o ^ miss_ext_o)); // R3

endmodule

// File: tb/sim_vaddr_seg_check.sv
`timescale 1ns/1ps
module sim_vaddr_seg_check;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [63:0] va;
    logic [1:0]  ksu;
    logic        exl, erl, ux, sx;
    logic [1:0]  mode;
    logic        wide, hit, aerr, mnorm, mext, badm;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    vaddr_seg_check u0 (
        .clk_i(clk), .rst_i(rst), .req_i(req), .va_i(va),
        .ksu_i(ksu), .exl_i(exl), .erl_i(erl), .ux_i(ux), .sx_i(sx),
        .mode_o(mode), .wide_o(wide), .hit_o(hit), .addr_err_o(aerr),
        .miss_norm_o(mnorm), .miss_ext_o(mext), .bad_mode_o(badm)
    );

    function automatic logic [63:0] addr_of(input int i);
        if (i < 64) return 64'd1 << i;
        case (i)
            64: return 64'd0;
            65: return 64'h0000_0000_7FFF_FFFF;
            66: return 64'h0000_0000_8000_0000;
            67: return 64'h0000_00FF_FFFF_FFFF;
            68: return 64'h0000_0100_0000_0000;
            69: return 64'hFFFF_FFFF_8000_0000;
            70: return 64'hFFFF_FFFF_0000_1234;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Expected {mode, wide, hit, err, norm, ext, bad}, worked out arithmetically.
    function automatic logic [7:0] expect_of(input logic [1:0] k, input logic e, input logic r,
                                             input logic u, input logic s, input logic [63:0] a,
                                             output string tag);
        logic [1:0] m;
        logic w, h, er, vn, vx, b;
        m = 2'd0; w = 0; h = 0; er = 0; vn = 0; vx = 0; b = 0;
        if (e || r) begin
            tag = "R1 R7";
        end else if (k == 2'd2) begin
            m = 2'd2; w = u;
            if (!u) begin
                if ((a % 64'h1_0000_0000) < 64'h8000_0000) begin h = 1; vn = 1; tag = "R3"; end
                else begin er = 1; tag = "R4 R11"; end
            end else begin
                if (a < 64'h0000_0100_0000_0000) begin h = 1; vx = 1; tag = "R5"; end
                else begin er = 1; tag = "R6 R11"; end
            end
        end else if (k == 2'd1) begin
            m = 2'd1; w = s; tag = "R2 R7";
        end else if (k == 2'd3) begin
            m = 2'd3; b = 1; tag = "R8";
        end else begin
            tag = "R1 R2";
        end
        return {m, w, h, er, vn, vx, b};
    endfunction

    function automatic logic [7:0] outs();
        return {mode, wide, hit, aerr, mnorm, mext, badm};
    endfunction

    task automatic check(input logic [7:0] exp, input string tag);
        n_tests++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (va=%h ksu=%b exl=%b erl=%b ux=%b sx=%b)",
                     tag, outs(), exp, va, ksu, exl, erl, ux, sx);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] exp;
        string tag;
        rst = 1; req = 0; va = '0; ksu = 2'b10; exl = 0; erl = 0; ux = 0; sx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(8'd0, "R10 reset state");
        rst = 0;

        for (int cfg = 0; cfg < 64; cfg++) begin
            for (int ai = 0; ai < 72; ai++) begin
                @(negedge clk);
                {ksu, exl, erl, ux, sx} = cfg[5:0];
                va  = addr_of(ai);
                req = 1;
                exp = expect_of(ksu, exl, erl, ux, sx, va, tag);
                @(posedge clk);
                @(negedge clk);
                check(exp, tag);
            end
            // idle cycle with a user-mode error address: outputs must be all zero (R9)
            req = 0; va = 64'hFFFF_FFFF_FFFF_FFFF; ksu = 2'b10; exl = 0; erl = 0; ux = 0;
            @(posedge clk);
            @(negedge clk);
            check(8'd0, "R9 idle");
        end

        // R10: reset during a live request clears outputs on the next edge
        @(negedge clk);
        req = 1; ksu = 2'b11; exl = 0; erl = 0; va = 64'h1;
        @(posedge clk);
        @(negedge clk);
        check(8'b11_000001, "R8 before reset");
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        check(8'd0, "R10 reset over request");
        rst = 0; req = 0;
        @(posedge clk);
        @(negedge clk);
        check(8'd0, "R9 after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule